// File: doc/BRIEF.md
# Four-Entry Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small direct-mapped table of four 2-bit saturating-style counters. The fetch stage presents the address of a branch on the lookup port. The block answers in the same cycle, with no register in the path, with a taken or not-taken guess. The guess comes from the counter that the address selects.

When the branch later resolves, the execute stage presents its address and real outcome on the update port. On the next rising clock edge, the selected counter moves to a new state. The transition table is deliberately asymmetric:

- A weak not-taken counter that sees a taken branch jumps directly to strong taken.
- A weak taken counter that sees a not-taken branch falls directly to strong not-taken.

Only branch direction is predicted. Targets, return addresses and global history are handled elsewhere in the pipeline.

Top module: `bp_pred_tbl`

## Requirements
- R1: After reset every counter holds state 00, so a lookup of any of the four slots predicts not taken.
- R2: A counter in state 00 or 01 predicts not taken (lk_take = 0); a counter in state 10 or 11 predicts taken (lk_take = 1).
- R3: The slot is selected by address bits [3:2] on both ports (0x0 → slot 0, 0x4 → slot 1, 0x8 → slot 2, 0xC → slot 3); all other address bits have no effect.
- R4: A counter in state 00 moves to 01 on a taken update and stays at 00 on a not-taken update.
- R5: A counter in state 01 moves to 11 on a taken update and to 00 on a not-taken update.
- R6: A counter in state 10 moves to 11 on a taken update and to 00 on a not-taken update.
- R7: A counter in state 11 stays at 11 on a taken update and moves to 10 on a not-taken update.
- R8: While up_valid is low, no counter changes, whatever up_addr and up_taken hold.
- R9: An update changes only the counter its address selects; the other three keep their state.
- R10: The lookup is combinational and an update takes effect at the next rising clock edge, so a lookup that hits the slot being updated in the same cycle returns the prediction of the state before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| lk_addr | input | 32 | Address of the branch being predicted |
| lk_take | output | 1 | Prediction for lk_addr: 1 = taken, 0 = not taken |
| up_valid | input | 1 | High when a resolved branch is presented on the update port |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch: 1 = taken |

## Verification
A corrupted counter cannot be seen directly at the ports. It only shows up through lk_take when its slot is looked up, and the effect depends on the bad state. A wrong high bit changes the guess in the very next lookup. A wrong low bit changes nothing until the following update: a 00 and a 01 both predict not taken, but a taken outcome sends one to 01 and the other to 11. The bench therefore drives update sequences that push each slot through both states of a pair. A slip in the low bit then turns into a wrong prediction one cycle after the distinguishing update.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Counter states. The encoding is observable: bit 1 is the direction guess.
  typedef enum logic [1:0] {
    ST_NOT_STRONG  = 2'b00,
    ST_NOT_WEAK    = 2'b01,
    ST_TAKE_WEAK   = 2'b10,
    ST_TAKE_STRONG = 2'b11
  } ctr_state_e;

  function automatic logic predicts_taken(input ctr_state_e s);
    return s[1];
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  // Bits outside the index field are intentionally dropped.
  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  assign idx = addr[IDX_LSB +: IDX_W];

endmodule

// File: rtl/bp_next_state.sv
module bp_next_state
  import bp_pkg::*;
(
  input  ctr_state_e cur,
  input  logic       taken,
  output ctr_state_e nxt
);

  always_comb begin
    unique case (cur)
      ST_NOT_STRONG:  nxt = taken ? ST_NOT_WEAK    : ST_NOT_STRONG;
      ST_NOT_WEAK:    nxt = taken ? ST_TAKE_STRONG : ST_NOT_STRONG;
      ST_TAKE_WEAK:   nxt = taken ? ST_TAKE_STRONG : ST_NOT_STRONG;
      ST_TAKE_STRONG: nxt = taken ? ST_TAKE_STRONG : ST_TAKE_WEAK;
      default:        nxt = ST_NOT_STRONG;
    endcase
  end

endmodule

// File: rtl/bp_slot_reg.sv
module bp_slot_reg
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  ctr_state_e wr_state,
  output ctr_state_e state_q
);

  ctr_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      state_d = wr_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NOT_STRONG;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/bp_pred_tbl.sv
module bp_pred_tbl
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SLOTS  = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_take,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);

  localparam int IDX_W   = $clog2(NUM_SLOTS);
  localparam int IDX_LSB = $clog2(INSN_BYTES);

  logic             rst_q_n;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr_state_e       slot_q [NUM_SLOTS];
  ctr_state_e       up_cur;
  ctr_state_e       up_nxt;
  ctr_state_e       lk_state;

  bp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_index (
    .addr (lk_addr),
    .idx  (lk_idx)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_up_index (
    .addr (up_addr),
    .idx  (up_idx)
  );

  // One shared transition function for the single update port.
  assign up_cur = slot_q[up_idx];

  bp_next_state u_next (
    .cur   (up_cur),
    .taken (up_taken),
    .nxt   (up_nxt)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(g);
    logic wr_en;

    assign wr_en = up_valid && (up_idx == SLOT_ID);

    bp_slot_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .wr_en    (wr_en),
      .wr_state (up_nxt),
      .state_q  (slot_q[g])
    );
  end

  // Lookup reads the registered state: same-cycle updates are not forwarded.
  assign lk_state = slot_q[lk_idx];
  assign lk_take  = predicts_taken(lk_state);

endmodule

// File: rtl/bp_pred_tbl_chk.sv
module bp_pred_tbl_chk
  import bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic [IDX_W-1:0] up_idx,
  input logic             up_taken,
  input logic [IDX_W-1:0] lk_idx,
  input logic             lk_take,
  input ctr_state_e       slot_q [NUM_SLOTS]
);

  // R2
  take_only_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_take |-> (slot_q[lk_idx] == ST_TAKE_WEAK || slot_q[lk_idx] == ST_TAKE_STRONG));

  // R2
  not_take_only_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_take |-> (slot_q[lk_idx] == ST_NOT_STRONG || slot_q[lk_idx] == ST_NOT_WEAK));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
    localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(g);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> slot_q[g] == ST_NOT_STRONG);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(slot_q[g]));

    // R9
    other_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_idx != SLOT_ID) |=> $stable(slot_q[g]));

    // R4
    from_not_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_idx == SLOT_ID && slot_q[g] == ST_NOT_STRONG) |=>
        slot_q[g] == ($past(up_taken) ? ST_NOT_WEAK : ST_NOT_STRONG));

    // R5
    from_not_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_idx == SLOT_ID && slot_q[g] == ST_NOT_WEAK) |=>
        slot_q[g] == ($past(up_taken) ? ST_TAKE_STRONG : ST_NOT_STRONG));

    // R6
    from_take_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_idx == SLOT_ID && slot_q[g] == ST_TAKE_WEAK) |=>
        slot_q[g] == ($past(up_taken) ? ST_TAKE_STRONG : ST_NOT_STRONG));

    // R7
    from_take_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_idx == SLOT_ID && slot_q[g] == ST_TAKE_STRONG) |=>
        slot_q[g] == ($past(up_taken) ? ST_TAKE_STRONG : ST_TAKE_WEAK));
  end

endmodule

bind bp_pred_tbl bp_pred_tbl_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .up_valid (up_valid),
  .up_idx   (up_idx),
  .up_taken (up_taken),
  .lk_idx   (lk_idx),
  .lk_take  (lk_take),
  .slot_q   (slot_q)
);

// File: tb/tb_bp_pred_tbl.sv
`timescale 1ns/1ps
module tb_bp_pred_tbl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_addr;
  logic        lk_take;
  logic        up_valid;
  logic [31:0] up_addr;
  logic        up_taken;

  int vectors  = 0;
  int miscmp   = 0;
  bit finished = 1'b0;
  int model [4];

  always #2.5 clk = ~clk;

  bp_pred_tbl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (lk_addr),
    .lk_take  (lk_take),
    .up_valid (up_valid),
    .up_addr  (up_addr),
    .up_taken (up_taken)
  );

  // Behavioural transition table (R4..R7).
  function automatic int next_of(input int s, input bit t);
    case (s)
      0:       return t ? 1 : 0;
      1:       return t ? 3 : 0;
      2:       return t ? 3 : 0;
      default: return t ? 3 : 2;
    endcase
  endfunction

  // Drive one cycle. Compare the prediction against the pre-update model
  // (R10). The update only becomes visible from the following cycle on.
  task automatic step(input logic [31:0] la, input bit uv, input logic [31:0] ua,
                      input bit ut, input string tag);
    bit exp;
    @(negedge clk);
    lk_addr  = la;
    up_valid = uv;
    up_addr  = ua;
    up_taken = ut;
    #1;
    exp = (model[la[3:2]] >= 2);
    vectors++;
    if (lk_take !== exp) begin
      miscmp++;
      $display("FAIL %s: lk_addr=%h lk_take=%0b expected %0b", tag, la, lk_take, exp);
    end
    if (uv) model[ua[3:2]] = next_of(model[ua[3:2]], ut);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscmp++;
      $display("FAIL watchdog: run still active, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    rst_n = 1'b0; lk_addr = '0; up_valid = 1'b0; up_addr = '0; up_taken = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: all slots not taken after reset
    for (int i = 0; i < 4; i++) step(32'(i * 4), 1'b0, '0, 1'b0, "R1");

    // Slot 0: 00 -T-> 01 -T-> 11 -N-> 10 -N-> 00
    step(32'h0, 1'b1, 32'h0, 1'b1, "R4");
    step(32'h0, 1'b0, 32'h0, 1'b0, "R4");
    step(32'h0, 1'b1, 32'h0, 1'b1, "R5");
    step(32'h0, 1'b0, 32'h0, 1'b0, "R5");
    step(32'h0, 1'b1, 32'h0, 1'b0, "R7");
    step(32'h0, 1'b0, 32'h0, 1'b0, "R7");
    step(32'h0, 1'b1, 32'h0, 1'b0, "R6");
    step(32'h0, 1'b0, 32'h0, 1'b0, "R6");
    step(32'h0, 1'b1, 32'h0, 1'b0, "R4");
    step(32'h0, 1'b0, 32'h0, 1'b0, "R4");

    // Slot 1: 01 -N-> 00, then two takens must reach 11
    step(32'h4, 1'b1, 32'h4, 1'b1, "R4");
    step(32'h4, 1'b1, 32'h4, 1'b0, "R5");
    step(32'h4, 1'b1, 32'h4, 1'b1, "R4");
    step(32'h4, 1'b1, 32'h4, 1'b1, "R5");
    step(32'h4, 1'b0, 32'h0, 1'b0, "R5");

    // Slot 2: 11 -N-> 10 -T-> 11 -N-> 10 -N-> 00
    step(32'h8, 1'b1, 32'h8, 1'b1, "R4");
    step(32'h8, 1'b1, 32'h8, 1'b1, "R5");
    step(32'h8, 1'b1, 32'h8, 1'b0, "R7");
    step(32'h8, 1'b1, 32'h8, 1'b1, "R6");
    step(32'h8, 1'b1, 32'h8, 1'b1, "R7");
    step(32'h8, 1'b1, 32'h8, 1'b0, "R7");
    step(32'h8, 1'b1, 32'h8, 1'b0, "R6");
    step(32'h8, 1'b0, 32'h8, 1'b0, "R6");

    // R3: upper address bits ignored on both ports
    step(32'hFFFF_FFF8, 1'b1, 32'h1234_5678, 1'b1, "R3");
    step(32'hABCD_0008, 1'b1, 32'h8000_000A, 1'b1, "R3");
    step(32'h7777_7779, 1'b0, 32'h0, 1'b0, "R3");
    step(32'h0000_00F4, 1'b0, 32'h0, 1'b0, "R3");

    // R8: updates without valid leave slot 3 untouched
    for (int i = 0; i < 4; i++) step(32'hC, 1'b0, 32'hC, 1'b1, "R8");
    step(32'hC, 1'b1, 32'hC, 1'b1, "R8");
    step(32'hC, 1'b0, 32'hC, 1'b1, "R8");

    // R10: same-slot lookup and update in one cycle sees the old state
    step(32'hC, 1'b1, 32'hC, 1'b1, "R10");
    step(32'hC, 1'b1, 32'hC, 1'b0, "R10");
    step(32'hC, 1'b1, 32'hC, 1'b0, "R10");
    step(32'hC, 1'b0, 32'hC, 1'b0, "R10");

    // R9: hammer slot 0, the others keep their state
    for (int i = 0; i < 3; i++) step(32'h0, 1'b1, 32'h0, 1'b1, "R9");
    for (int i = 1; i < 4; i++) step(32'(i * 4), 1'b0, '0, 1'b0, "R9");

    // R2 and mixed traffic: random addresses and outcomes
    for (int i = 0; i < 2000; i++) begin
      step($urandom, 1'($urandom), $urandom, 1'($urandom), "R2");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule